// File: doc/BRIEF.md
# Packed Byte Variable Left Shifter

This block is the execute-stage unit for one SIMD operation. It treats a 32-bit source operand as four unsigned byte lanes and shifts every lane left by one common amount. The amount is taken from the low three bits of a second operand. Each lane is shifted on its own: bits leave the top of a lane and are discarded, and zeros enter at the bottom. If any lane loses a 1 bit, the block sets a sticky overflow bit in the DSP control register.

The pipeline presents a 32-bit instruction word with an `issue` strobe, the two operand values read from the register file, the current DSP control register and the DSP-enable state. The block decodes the word and computes the lane results, the overflow and the control-register update. All of this is registered on the next rising edge. When DSP resources are disabled, the block raises an exception in place of any write.

Top module: `pbsl_exec`

## Requirements
- R1: The operation is recognised when instr[31:26] = 6'b001000, instr[9:3] = 7'b1110010 and instr[2:0] = 3'b101. instr[10] has no effect on recognition. The data source index is instr[25:21], the amount source index is instr[20:16] and the destination index is instr[15:11].
- R2: After an edge where `issue` is low or the word is not recognised, `out_valid`, `rd_we`, `ctrl_we` and `dsp_exc` are all 0.
- R3: The shift amount is `rs_val[2:0]`, unsigned 0 to 7. `rs_val[31:3]` has no effect on any output.
- R4: Each byte lane `rt_val[8k+7:8k]` (k = 0..3) is shifted left by the amount with zero fill and is written to `rd_data[8k+7:8k]`. No bit crosses into another lane.
- R5: A recognised operation issued with `dsp_en` = 1 gives `out_valid` = 1, `rd_we` = 1, the result on `rd_data` and the destination index on `rd_idx`. These appear one clock edge after the issue edge.
- R6: A lane overflows when a 1 bit is among the bits shifted out of its top. If any lane overflows, `ctrl_we` = 1 and `ctrl_out` equals the sampled `ctrl_in` with bit 22 forced to 1 and every other bit unchanged.
- R7: When no lane overflows, `ctrl_we` stays 0, so bit 22 is left as it was and is never cleared. An amount of 0 never overflows and returns each lane unchanged.
- R8: A recognised operation issued with `dsp_en` = 0 gives `out_valid` = 1 and `dsp_exc` = 1, with `rd_we` = 0 and `ctrl_we` = 0.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Instruction word and operands are present this cycle |
| instr | input | 32 | Instruction word |
| dsp_en | input | 1 | DSP resources enabled |
| rs_val | input | 32 | Amount operand; only bits 2:0 are used |
| rt_val | input | 32 | Packed byte data operand |
| ctrl_in | input | 32 | Current DSP control register value |
| out_valid | output | 1 | A recognised operation completed |
| rd_we | output | 1 | Write `rd_data` to register `rd_idx` |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Packed shifted result |
| ctrl_we | output | 1 | Write `ctrl_out` to the DSP control register |
| ctrl_out | output | 32 | Updated control register value |
| dsp_exc | output | 1 | DSP-disabled exception |

## Verification
The bench drives the top bit of one lane with an amount of 1. A shifter that let bits leak between lanes would then put a 1 in the lowest bit of the lane above, and the bench checks that this does not happen. It also sets high bits in the amount operand, which a design that used more than three bits would turn into larger shifts or cleared lanes. Amounts of 0 and 7 are tried with all-ones and single-bit patterns, to catch overflow masks that are off by one and a zero shift that raises the flag. The bench further gives an already-set flag with no overflow, a disabled unit, the don't-care bit set, and opcode words that differ in one field. A design that cleared the sticky bit, wrote while disabled, or decoded too loosely or too strictly would fail one of these.

// File: rtl/pbsl_pkg.sv
package pbsl_pkg;

   localparam int INSTR_W   = 32;
   localparam int REG_IDX_W = 5;

   typedef logic [REG_IDX_W-1:0] reg_idx_t;

   // Field layout of the instruction word, most significant field first.
   typedef struct packed {
      logic [5:0] major;
      reg_idx_t   src_data;
      reg_idx_t   src_amt;
      reg_idx_t   dst;
      logic       spare;
      logic [6:0] func;
      logic [2:0] sub;
   } instr_fields_t;

   localparam logic [5:0] MAJOR_CODE = 6'b001000;
   localparam logic [6:0] FUNC_CODE  = 7'b1110010;
   localparam logic [2:0] SUB_CODE   = 3'b101;

endpackage

// File: rtl/pbsl_decode.sv
module pbsl_decode
   import pbsl_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output logic               match,
   output reg_idx_t           data_idx,
   output reg_idx_t           amt_idx,
   output reg_idx_t           dst_idx
);

   instr_fields_t f;

   initial begin
      if ($bits(instr_fields_t) != INSTR_W)
         $error("pbsl_decode: field layout does not fill the instruction word");
   end

   always_comb begin
      f        = instr_fields_t'(instr);
      // The spare bit takes no part in recognition.
      match    = (f.major == MAJOR_CODE) &&
                 (f.func  == FUNC_CODE)  &&
                 (f.sub   == SUB_CODE);
      data_idx = f.src_data;
      amt_idx  = f.src_amt;
      dst_idx  = f.dst;
   end

endmodule

// File: rtl/pbsl_lane.sv
module pbsl_lane #(
   parameter int  LANE_W     = 8,
   parameter bit  USE_STAGED = 1'b1,
   localparam int SH_W       = $clog2(LANE_W)
) (
   input  logic [LANE_W-1:0] din,
   input  logic [SH_W-1:0]   shamt,
   output logic [LANE_W-1:0] res,
   output logic              ovf
);

   localparam logic [LANE_W-1:0] ONES = {LANE_W{1'b1}};

   initial begin
      if (LANE_W < 2)
         $error("pbsl_lane: LANE_W must be at least 2");
      if ((1 << SH_W) != LANE_W)
         $error("pbsl_lane: LANE_W must be a power of two");
   end

   generate
      if (USE_STAGED) begin : g_staged
         // Logarithmic shifter: stage k moves by 2**k and records the
         // bits it pushes past the top of the lane.
         logic [SH_W:0][LANE_W-1:0] st;
         logic [SH_W-1:0]           lost;

         always_comb begin
            st[0] = din;
            for (int k = 0; k < SH_W; k++) begin
               if (shamt[k]) begin
                  st[k+1] = st[k] << (1 << k);
                  lost[k] = |(st[k] & ~(ONES >> (1 << k)));
               end else begin
                  st[k+1] = st[k];
                  lost[k] = 1'b0;
               end
            end
            res = st[SH_W];
            ovf = |lost;
         end
      end else begin : g_direct
         // Single barrel shift with the overflow mask taken from the amount.
         always_comb begin
            res = din << shamt;
            ovf = |(din & ~(ONES >> shamt));
         end
      end
   endgenerate

   // R7
   always_comb begin
      if (shamt == '0) begin
         zero_shift_identity_chk: assert (res == din && !ovf);
      end
   end

endmodule

// File: rtl/pbsl_flag.sv
module pbsl_flag #(
   parameter int LANES    = 4,
   parameter int CTRL_W   = 32,
   parameter int FLAG_BIT = 22
) (
   input  logic [LANES-1:0]  lane_ovf,
   input  logic [CTRL_W-1:0] ctrl_in,
   output logic              any_ovf,
   output logic [CTRL_W-1:0] ctrl_next
);

   localparam logic [CTRL_W-1:0] FLAG_MASK = CTRL_W'(1) << FLAG_BIT;

   initial begin
      if (FLAG_BIT < 0 || FLAG_BIT >= CTRL_W)
         $error("pbsl_flag: FLAG_BIT outside control register");
   end

   always_comb begin
      any_ovf   = |lane_ovf;
      // Sticky: only sets the bit, never clears it.
      ctrl_next = ctrl_in | FLAG_MASK;
   end

endmodule

// File: rtl/pbsl_exec.sv
module pbsl_exec #(
   parameter int LANES      = 4,
   parameter int LANE_W     = 8,
   parameter int CTRL_W     = 32,
   parameter int FLAG_BIT   = 22,
   parameter bit USE_STAGED = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     issue,
   input  logic [31:0]              instr,
   input  logic                     dsp_en,
   input  logic [LANES*LANE_W-1:0]  rs_val,
   input  logic [LANES*LANE_W-1:0]  rt_val,
   input  logic [CTRL_W-1:0]        ctrl_in,
   output logic                     out_valid,
   output logic                     rd_we,
   output logic [4:0]               rd_idx,
   output logic [LANES*LANE_W-1:0]  rd_data,
   output logic                     ctrl_we,
   output logic [CTRL_W-1:0]        ctrl_out,
   output logic                     dsp_exc
);
   import pbsl_pkg::*;

   localparam int DATA_W = LANES * LANE_W;
   localparam int SH_W   = $clog2(LANE_W);
   localparam logic [CTRL_W-1:0] FLAG_MASK = CTRL_W'(1) << FLAG_BIT;

   initial begin
      if (LANES < 1)
         $error("pbsl_exec: LANES must be positive");
      if (DATA_W > 64)
         $error("pbsl_exec: operand width too large");
   end

   // Decode
   logic     hit;
   reg_idx_t data_idx, amt_idx, dst_idx;

   pbsl_decode u_dec (
      .instr    (instr),
      .match    (hit),
      .data_idx (data_idx),
      .amt_idx  (amt_idx),
      .dst_idx  (dst_idx)
   );

   // Lanes share the amount taken from the low bits of rs.
   logic [SH_W-1:0]   shamt;
   logic [DATA_W-1:0] shifted;
   logic [LANES-1:0]  lane_ovf;

   assign shamt = rs_val[SH_W-1:0];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      pbsl_lane #(
         .LANE_W     (LANE_W),
         .USE_STAGED (USE_STAGED)
      ) u_lane (
         .din   (rt_val[g*LANE_W +: LANE_W]),
         .shamt (shamt),
         .res   (shifted[g*LANE_W +: LANE_W]),
         .ovf   (lane_ovf[g])
      );
   end

   // Control register update
   logic              any_ovf;
   logic [CTRL_W-1:0] ctrl_next;

   pbsl_flag #(
      .LANES    (LANES),
      .CTRL_W   (CTRL_W),
      .FLAG_BIT (FLAG_BIT)
   ) u_flag (
      .lane_ovf  (lane_ovf),
      .ctrl_in   (ctrl_in),
      .any_ovf   (any_ovf),
      .ctrl_next (ctrl_next)
   );

   // Qualification and output register
   logic fire, commit, trap;

   always_comb begin
      fire   = issue & hit;
      commit = fire & dsp_en;
      trap   = fire & ~dsp_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         rd_we     <= 1'b0;
         rd_idx    <= '0;
         rd_data   <= '0;
         ctrl_we   <= 1'b0;
         ctrl_out  <= '0;
         dsp_exc   <= 1'b0;
      end else begin
         out_valid <= fire;
         rd_we     <= commit;
         rd_idx    <= commit ? dst_idx : '0;
         rd_data   <= commit ? shifted : '0;
         ctrl_we   <= commit & any_ovf;
         ctrl_out  <= (commit & any_ovf) ? ctrl_next : '0;
         dsp_exc   <= trap;
      end
   end

   // R8
   exc_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_exc |-> (!rd_we && !ctrl_we && out_valid));

   // R6
   flag_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |-> rd_we);

   // R6
   flag_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |-> ctrl_out[FLAG_BIT]);

   // R6
   flag_others_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |-> ((ctrl_out & ~FLAG_MASK) == ($past(ctrl_in) & ~FLAG_MASK)));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> (!out_valid && !rd_we && !ctrl_we && !dsp_exc));

   // R7
   zero_shift_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && rs_val[SH_W-1:0] == '0) |=> !ctrl_we);

   // R5
   write_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && hit && dsp_en) |=> (rd_we && out_valid));

endmodule

// File: tb/tb_pbsl_exec.sv
`timescale 1ns/1ps
module tb_pbsl_exec;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        issue;
   logic [31:0] instr;
   logic        dsp_en;
   logic [31:0] rs_val, rt_val, ctrl_in;
   logic        out_valid, rd_we, ctrl_we, dsp_exc;
   logic [4:0]  rd_idx;
   logic [31:0] rd_data, ctrl_out;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pbsl_exec dut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
      .dsp_en(dsp_en), .rs_val(rs_val), .rt_val(rt_val), .ctrl_in(ctrl_in),
      .out_valid(out_valid), .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
      .ctrl_we(ctrl_we), .ctrl_out(ctrl_out), .dsp_exc(dsp_exc)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(logic [4:0] rt, logic [4:0] rs,
                                      logic [4:0] rd, logic spare);
      return {6'b001000, rt, rs, rd, spare, 7'b1110010, 3'b101};
   endfunction

   function automatic bit ref_match(logic [31:0] w);
      return w[31:26] == 6'b001000 && w[9:3] == 7'b1110010 && w[2:0] == 3'b101;
   endfunction

   function automatic logic [31:0] ref_shift(logic [31:0] d, logic [2:0] sa);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) begin
         logic [7:0] b;
         b = d[8*i +: 8];
         r[8*i +: 8] = 8'(b << sa);
      end
      return r;
   endfunction

   function automatic bit ref_ovf(logic [31:0] d, logic [2:0] sa);
      bit o = 1'b0;
      for (int i = 0; i < 4; i++) begin
         logic [15:0] wide;
         wide = {8'h00, d[8*i +: 8]} << sa;
         if (wide[15:8] != 8'h00) o = 1'b1;
      end
      return o;
   endfunction

   // Drive one cycle at a falling edge, check at the next falling edge.
   task automatic run_op(string req, logic iss, logic [31:0] w, logic en,
                         logic [31:0] rs, logic [31:0] rt, logic [31:0] ci);
      bit hit, wr, ov;
      issue = iss; instr = w; dsp_en = en; rs_val = rs; rt_val = rt; ctrl_in = ci;
      hit = iss && ref_match(w);
      wr  = hit && en;
      ov  = wr && ref_ovf(rt, rs[2:0]);
      @(negedge clk);
      chk({req, " out_valid"}, 32'(out_valid), 32'(hit));
      chk({req, " rd_we"},     32'(rd_we),     32'(wr));
      chk({req, " dsp_exc"},   32'(dsp_exc),   32'(hit && !en));
      chk({req, " ctrl_we"},   32'(ctrl_we),   32'(ov));
      if (wr) begin
         chk({req, " rd_data"}, rd_data, ref_shift(rt, rs[2:0]));
         chk({req, " rd_idx"},  32'(rd_idx), 32'(w[15:11]));
      end
      if (ov) chk({req, " ctrl_out"}, ctrl_out, ci | 32'h0040_0000);
      issue = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; issue = 1'b0; instr = '0; dsp_en = 1'b0;
      rs_val = '0; rt_val = '0; ctrl_in = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 out_valid", 32'(out_valid), 0);
      chk("R9 rd_we",     32'(rd_we), 0);
      chk("R9 rd_data",   rd_data, 0);
      chk("R9 ctrl_we",   32'(ctrl_we), 0);
      chk("R9 dsp_exc",   32'(dsp_exc), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 matching word without issue, and words off by one field
      run_op("R2 no issue", 1'b0, mk(5'd1, 5'd2, 5'd3, 1'b0), 1'b1, 32'd3, 32'hFFFF_FFFF, 0);
      run_op("R2 bad major", 1'b1, mk(5'd1, 5'd2, 5'd3, 1'b0) ^ 32'h0400_0000, 1'b1, 32'd3, 32'hFFFF_FFFF, 0);
      run_op("R2 bad func", 1'b1, mk(5'd1, 5'd2, 5'd3, 1'b0) ^ 32'h0000_0008, 1'b1, 32'd3, 32'hFFFF_FFFF, 0);
      run_op("R2 bad sub", 1'b1, mk(5'd1, 5'd2, 5'd3, 1'b0) ^ 32'h0000_0001, 1'b1, 32'd3, 32'hFFFF_FFFF, 0);
      // R1 spare bit set still matches
      run_op("R1 spare bit", 1'b1, mk(5'd4, 5'd5, 5'd17, 1'b1), 1'b1, 32'd2, 32'h1234_5678, 0);
      // R7 zero shift: unchanged, no flag even for all ones
      run_op("R7 zero shift", 1'b1, mk(5'd1, 5'd2, 5'd9, 1'b0), 1'b1, 32'd0, 32'hFFFF_FFFF, 0);
      // R4 max shift without loss
      run_op("R4 shift 7", 1'b1, mk(5'd1, 5'd2, 5'd10, 1'b0), 1'b1, 32'd7, 32'h0101_0101, 0);
      // R4 no carry across lanes, R6 overflow from one lane
      run_op("R4 R6 lane top", 1'b1, mk(5'd1, 5'd2, 5'd11, 1'b0), 1'b1, 32'd1, 32'h0080_0000, 32'h1234_0001);
      // R3 high bits of rs ignored
      run_op("R3 rs high bits", 1'b1, mk(5'd1, 5'd2, 5'd12, 1'b0), 1'b1, 32'hFFFF_FFF9, 32'h4321_8765, 0);
      // R7 sticky bit already set, no overflow: no write
      run_op("R7 sticky kept", 1'b1, mk(5'd1, 5'd2, 5'd13, 1'b0), 1'b1, 32'd1, 32'h3F3F_3F3F, 32'h0040_0000);
      // R6 overflow at shift 7 from lane 0 bit 1
      run_op("R6 shift 7 ovf", 1'b1, mk(5'd1, 5'd2, 5'd14, 1'b0), 1'b1, 32'd7, 32'h0000_0002, 32'hA5A5_A5A5);
      // R8 disabled unit
      run_op("R8 disabled", 1'b1, mk(5'd1, 5'd2, 5'd15, 1'b0), 1'b0, 32'd4, 32'hFFFF_FFFF, 0);
      // R5 back-to-back issue
      run_op("R5 back to back", 1'b1, mk(5'd3, 5'd4, 5'd31, 1'b0), 1'b1, 32'd5, 32'h0F0F_0F0F, 0);

      // Random mix
      for (int n = 0; n < 600; n++) begin
         logic [31:0] w;
         if ($urandom_range(9) < 7)
            w = mk(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom));
         else
            w = $urandom;
         run_op("R4 R5 R6 random", 1'($urandom_range(7) != 0), w,
                1'($urandom_range(5) != 0), $urandom, $urandom, $urandom);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule